// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

A purely combinational adder for two WIDTH-bit unsigned operands and a carry input. It returns a WIDTH-bit sum and a carry output. The operand bits are cut into consecutive blocks. The lowest block is a plain ripple adder driven straight from the carry input.

Every higher block builds its propagate and generate terms first. It then runs two ripple carry chains side by side: one assumes the block receives a carry of 0, the other assumes a carry of 1. Once the real carry arrives from the block below, a multiplexer passes on the matching sum bits and the matching block carry. Each step from block to block therefore costs one multiplexer, not a full ripple through the block.

A parameter chooses the block sizing.
- In square-root sizing, the first block is FIRST_LEN bits long and each later block is one bit longer than the block before it.
- In linear sizing, every block is STEP_LEN bits long.

In both modes the last block takes whatever bits remain, so the block lengths always add up to WIDTH. The block is meant to sit inside a datapath. It has no registers.

Top module: `csa_sqrt_adder`

## Requirements
- R1: `{cout, sum}` equals the unsigned value `a + b + cin`, computed WIDTH+1 bits wide, for every input pattern in both sizing modes.
- R2: With SQRT_MODE=1, WIDTH=20 and FIRST_LEN=2, the blocks cover bits [1:0], [4:2], [8:5], [13:9] and [19:14]. A carry generated at the top bit of any block reaches bit 0 of the next block.
- R3: In every block except the lowest, the result of the chain that assumes carry 1 equals the result of the chain that assumes carry 0, plus one. The block's output is the result selected by its actual incoming carry.
- R4: When every bit of a block propagates (a XOR b all ones), the carry leaving the block equals the carry entering it. This holds across all blocks in a row. For example, with `a` all ones, `b` zero and `cin` 1, the outputs are `sum` zero and `cout` 1.
- R5: With SQRT_MODE=0, WIDTH=16 and STEP_LEN=4, the blocks are four 4-bit blocks at [3:0], [7:4], [11:8] and [15:12]. A carry crosses each of these boundaries correctly.
- R6: `cin` feeds the lowest block directly. With `a` and `b` both zero, `sum` equals `cin` and `cout` is 0.
- R7: `cout` is 1 exactly when `a + b + cin` is at least 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies of the adder side by side.
- The first uses square-root sizing: WIDTH=20 and FIRST_LEN=2, which gives five blocks of growing length. A carry forced into bit 0 of each block can then check every boundary at 2, 5, 9 and 14.
- The second uses linear sizing: WIDTH=16 and STEP_LEN=4, which gives four equal blocks with boundaries at 4, 8 and 12.

Both copies are driven with single-bit carry walks, all-propagate strings and pseudo-random operands, so both the selection multiplexers and the dual chains are exercised in each mode.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Nominal length of block k before clipping to the bits that remain.
  function automatic int nominal_len(bit sqrt_mode, int first_len, int step_len, int k);
    int base;
    base = (first_len < 1) ? 1 : first_len;
    if (sqrt_mode) return base + k;
    return (step_len < 1) ? 1 : step_len;
  endfunction

  // Length of block idx; zero once the operand bits are used up.
  function automatic int blk_len(int width, bit sqrt_mode, int first_len, int step_len, int idx);
    int lo;
    int res;
    lo  = 0;
    res = 0;
    for (int k = 0; k < width; k++) begin
      int rem;
      int sz;
      int len;
      rem = width - lo;
      sz  = nominal_len(sqrt_mode, first_len, step_len, k);
      len = (rem <= 0) ? 0 : ((rem < sz) ? rem : sz);
      if (k == idx) res = len;
      lo = lo + len;
    end
    return res;
  endfunction

  // Index of the lowest bit of block idx.
  function automatic int blk_lo(int width, bit sqrt_mode, int first_len, int step_len, int idx);
    int lo;
    lo = 0;
    for (int k = 0; k < width; k++) begin
      if (k < idx) lo = lo + blk_len(width, sqrt_mode, first_len, step_len, k);
    end
    return lo;
  endfunction

  // Count of non-empty blocks.
  function automatic int num_blocks(int width, bit sqrt_mode, int first_len, int step_len);
    int n;
    n = 0;
    for (int k = 0; k < width; k++) begin
      if (blk_len(width, sqrt_mode, first_len, step_len, k) > 0) n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/csa_pg_setup.sv
module csa_pg_setup #(
  parameter int LEN = 4
) (
  input  logic [LEN-1:0] op_a,
  input  logic [LEN-1:0] op_b,
  output logic [LEN-1:0] prop,
  output logic [LEN-1:0] gen
);
  genvar i;
  generate
    for (i = 0; i < LEN; i++) begin : g_bit
      assign prop[i] = op_a[i] ^ op_b[i];
      assign gen[i]  = op_a[i] & op_b[i];
    end
  endgenerate
endmodule

// File: rtl/csa_ripple_chain.sv
module csa_ripple_chain #(
  parameter int LEN = 4
) (
  input  logic [LEN-1:0] prop,
  input  logic [LEN-1:0] gen,
  input  logic           c_in,
  output logic [LEN-1:0] s_out,
  output logic           c_out
);
  logic [LEN:0] carry;

  assign carry[0] = c_in;

  genvar i;
  generate
    for (i = 0; i < LEN; i++) begin : g_stage
      assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
      assign s_out[i]   = prop[i] ^ carry[i];
    end
  endgenerate

  assign c_out = carry[LEN];

  // Full propagate string passes the incoming carry through unchanged.
  always_comb begin
    if (&prop) begin
      p_all_prop_r4: assert (c_out == c_in)
        else $error("all-propagate chain altered the carry");
    end
  end

  // With no propagating bit, the carry comes from the top generate alone.
  always_comb begin
    if (prop == '0) begin
      p_no_prop_r4: assert (c_out == gen[LEN-1])
        else $error("carry leaked through a non-propagating chain");
    end
  end
endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
  parameter int LEN = 4
) (
  input  logic [LEN-1:0] op_a,
  input  logic [LEN-1:0] op_b,
  input  logic           c_in,
  output logic [LEN-1:0] s_out,
  output logic           c_out
);
  logic [LEN-1:0] prop;
  logic [LEN-1:0] gen;
  logic [LEN-1:0] sum_if0;
  logic [LEN-1:0] sum_if1;
  logic           cout_if0;
  logic           cout_if1;

  csa_pg_setup #(.LEN(LEN)) u_setup (
    .op_a (op_a),
    .op_b (op_b),
    .prop (prop),
    .gen  (gen)
  );

  csa_ripple_chain #(.LEN(LEN)) u_chain0 (
    .prop  (prop),
    .gen   (gen),
    .c_in  (1'b0),
    .s_out (sum_if0),
    .c_out (cout_if0)
  );

  csa_ripple_chain #(.LEN(LEN)) u_chain1 (
    .prop  (prop),
    .gen   (gen),
    .c_in  (1'b1),
    .s_out (sum_if1),
    .c_out (cout_if1)
  );

  assign s_out = c_in ? sum_if1 : sum_if0;
  assign c_out = c_in ? cout_if1 : cout_if0;

  // The carry-1 chain is the carry-0 chain plus one.
  always_comb begin
    p_sel_offset_r3: assert ({cout_if1, sum_if1} == {cout_if0, sum_if0} + (LEN+1)'(1))
      else $error("dual chains disagree by more than one");
  end

  // A carry from the carry-0 chain implies one from the carry-1 chain.
  always_comb begin
    p_sel_order_r3: assert (!(cout_if0 && !cout_if1))
      else $error("carry-0 chain carries while carry-1 chain does not");
  end
endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder #(
  parameter int WIDTH     = 20,
  parameter bit SQRT_MODE = 1'b1,
  parameter int FIRST_LEN = 2,
  parameter int STEP_LEN  = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NBLK = csa_pkg::num_blocks(WIDTH, SQRT_MODE, FIRST_LEN, STEP_LEN);

  // Carry arriving at each block; blk_carry[NBLK] leaves the top block.
  logic [NBLK:0] blk_carry;

  assign blk_carry[0] = cin;

  genvar k;
  generate
    for (k = 0; k < NBLK; k++) begin : g_blk
      localparam int LO  = csa_pkg::blk_lo(WIDTH, SQRT_MODE, FIRST_LEN, STEP_LEN, k);
      localparam int LEN = csa_pkg::blk_len(WIDTH, SQRT_MODE, FIRST_LEN, STEP_LEN, k);
      if (k == 0) begin : g_ripple
        logic [LEN-1:0] prop;
        logic [LEN-1:0] gen;
        csa_pg_setup #(.LEN(LEN)) u_setup (
          .op_a (a[LO +: LEN]),
          .op_b (b[LO +: LEN]),
          .prop (prop),
          .gen  (gen)
        );
        csa_ripple_chain #(.LEN(LEN)) u_chain (
          .prop  (prop),
          .gen   (gen),
          .c_in  (blk_carry[k]),
          .s_out (sum[LO +: LEN]),
          .c_out (blk_carry[k+1])
        );
      end else begin : g_select
        csa_select_block #(.LEN(LEN)) u_sel (
          .op_a  (a[LO +: LEN]),
          .op_b  (b[LO +: LEN]),
          .c_in  (blk_carry[k]),
          .s_out (sum[LO +: LEN]),
          .c_out (blk_carry[k+1])
        );
      end
    end
  endgenerate

  assign cout = blk_carry[NBLK];

  // Whole-word result against a direct addition.
  always_comb begin
    p_total_r1: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin))
      else $error("adder result differs from a+b+cin");
  end

  // Carry out set exactly on overflow of the word.
  always_comb begin
    p_cout_r7: assert (cout == (({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)) >> WIDTH))
      else $error("carry out disagrees with overflow");
  end
endmodule

// File: tb/csa_sqrt_adder_bench.sv
module csa_sqrt_adder_bench;
  localparam int WS = 20;
  localparam int WL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [WS-1:0] sa, sb, ssum;
  logic          scin, scout;
  logic [WL-1:0] la, lb, lsum;
  logic          lcin, lcout;

  int checks = 0;
  int errors = 0;

  csa_sqrt_adder #(.WIDTH(WS), .SQRT_MODE(1'b1), .FIRST_LEN(2), .STEP_LEN(4)) u_csa_sqrt_adder (
    .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout)
  );

  csa_sqrt_adder #(.WIDTH(WL), .SQRT_MODE(1'b0), .FIRST_LEN(2), .STEP_LEN(4)) u_lin (
    .a(la), .b(lb), .cin(lcin), .sum(lsum), .cout(lcout)
  );

  task automatic run_sq(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic c,
                        input string req);
    logic [WS:0] exp_v;
    @(negedge clk);
    sa = x; sb = y; scin = c;
    @(posedge clk);
    #1;
    exp_v = WS'(0);
    for (int i = 0; i < WS; i++) exp_v = exp_v + ((WS+1)'(x[i]) << i) + ((WS+1)'(y[i]) << i);
    exp_v = exp_v + (WS+1)'(c);
    checks++;
    if ({scout, ssum} !== exp_v) begin
      errors++;
      $display("FAIL %s sqrt: a=%h b=%h cin=%b got %h expected %h", req, x, y, c,
               {scout, ssum}, exp_v);
    end
  endtask

  task automatic run_lin(input logic [WL-1:0] x, input logic [WL-1:0] y, input logic c,
                         input string req);
    logic [WL:0] exp_v;
    @(negedge clk);
    la = x; lb = y; lcin = c;
    @(posedge clk);
    #1;
    exp_v = (WL+1)'(x) + (WL+1)'(y) + (WL+1)'(c);
    checks++;
    if ({lcout, lsum} !== exp_v) begin
      errors++;
      $display("FAIL %s linear: a=%h b=%h cin=%b got %h expected %h", req, x, y, c,
               {lcout, lsum}, exp_v);
    end
  endtask

  // R6: zero operands pass cin to bit 0 only.
  task automatic t_reset_and_cin();
    run_sq('0, '0, 1'b0, "R6");
    run_sq('0, '0, 1'b1, "R6");
    run_lin('0, '0, 1'b1, "R6");
  endtask

  // R2: carry generated at each square-root block top bit.
  task automatic t_sqrt_boundaries();
    int tops[5] = '{1, 4, 8, 13, 19};
    foreach (tops[i]) begin
      run_sq(WS'(1) << tops[i], WS'(1) << tops[i], 1'b0, "R2");
      run_sq((WS'(1) << (tops[i] + 1)) - 1, WS'(0), 1'b1, "R2");
    end
  endtask

  // R5: carry across each equal linear boundary.
  task automatic t_linear_boundaries();
    for (int t = 3; t < WL; t += 4) begin
      run_lin(WL'(1) << t, WL'(1) << t, 1'b0, "R5");
      run_lin((WL'(1) << (t + 1)) - 1, WL'(1), 1'b0, "R5");
    end
  endtask

  // R4: all-propagate string carries cin through every block.
  task automatic t_propagate();
    run_sq('1, '0, 1'b1, "R4");
    run_sq(20'hAAAAA, 20'h55555, 1'b1, "R4");
    run_sq(20'hAAAAA, 20'h55555, 1'b0, "R4");
    run_lin('1, '0, 1'b1, "R4");
    run_lin(16'h5A5A, 16'hA5A5, 1'b1, "R4");
  endtask

  // R7 and R3: overflow and carry walks into each bit.
  task automatic t_overflow_walk();
    run_sq('1, '1, 1'b1, "R7");
    run_sq('1, WS'(1), 1'b0, "R7");
    run_lin(16'h8000, 16'h8000, 1'b0, "R7");
    for (int i = 0; i < WS; i++) run_sq(WS'(1) << i, '1, 1'b0, "R3");
  endtask

  // R1: pseudo-random operands for both configurations.
  task automatic t_random();
    logic [31:0] lfsr;
    lfsr = 32'hC0FFEE11;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_sq(lfsr[19:0], lfsr[31:12], lfsr[5], "R1");
      run_lin(lfsr[15:0], lfsr[31:16], lfsr[7], "R1");
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sa = '0; sb = '0; scin = 1'b0;
    la = '0; lb = '0; lcin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_and_cin();
    t_sqrt_boundaries();
    t_linear_boundaries();
    t_propagate();
    t_overflow_walk();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule